// File: doc/BRIEF.md
# SD Host Interrupt Status Unit

This block keeps the interrupt status word of an SD host controller. The command, data and DMA paths deliver one-cycle event pulses on a 32-bit vector, each event on its own fixed bit. An event is captured into a sticky status bit only when its bit is set in a capture-enable register. A second register, the line-enable register, chooses which captured bits may drive the single level-sensitive interrupt output. Software clears captured bits by writing ones to them.

Besides the sticky bits, the status word carries a summary bit that is set whenever any error bit is captured. A separate read-only word mirrors the command-busy, data-busy and data-line-active levels that the transfer logic supplies. All access goes through a simple register port: a word select, a write strobe, write data and combinational read data.

Top module: `sd_irq_unit`

## Requirements
- R1: While and right after reset, every readable word reads 0 (apart from the busy mirror, which follows its inputs) and `irq` is 0.
- R2: An event pulse on an implemented bit whose capture-enable bit is 1 sets that status bit at the next clock edge. The bit stays set after the pulse ends, until software clears it.
- R3: An event pulse on a bit whose capture-enable bit is 0 leaves the status bit at 0.
- R4: A write to select 0 clears every status bit whose write-data bit is 1. Status bits whose write-data bit is 0 keep their value, and writing all ones clears every bit.
- R5: If an enabled event and a write-one-to-clear hit the same bit in the same cycle, the bit is set after the edge.
- R6: `irq` is 1 exactly when some status bit is 1 and its line-enable bit (select 2) is 1. It follows status and line-enable changes with no extra register stage.
- R7: Status read bit 15 is 1 exactly when any of status bits 31..16 is 1.
- R8: Only these bits are implemented: normal bits 0, 1, 3, 4, 5, 6 and 8, and error bits 16 to 22, 24 and 28 (mask 0x117F017B). The other bits read 0 in the status word and in both enable registers (selects 1 and 2), and events on them are ignored.
- R9: Select 3 reads command busy on bit 0, data busy on bit 1 and data line active on bit 2. It follows these inputs in the same cycle, and writes to select 3 have no effect. Selects 4 to 7 read 0.
- R10: Clearing a capture-enable bit does not clear a status bit that is already captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Word select: 0 status, 1 capture enable, 2 line enable, 3 busy mirror |
| reg_wr | input | 1 | Write strobe for the selected word |
| reg_wdata | input | 32 | Write data (ones clear bits in the status word) |
| reg_rdata | output | 32 | Read data of the selected word, combinational |
| evt_in | input | 32 | One-cycle event pulses, one per status bit position |
| cmd_busy_in | input | 1 | Command line busy level |
| dat_busy_in | input | 1 | Data lines busy level |
| dat_active_in | input | 1 | Data line active level |
| irq | output | 1 | Level interrupt request |

## Verification
Read data and the busy mirror are combinational, so they are due in the same cycle as the select or busy-level change. Status bits, enable registers and `irq` change at the first rising edge after the event or write that causes them. The bench drives each cycle's inputs just after a falling edge. It compares read data and `irq` against its reference model one nanosecond later, before the rising edge, and only then advances the model by that edge. Every cycle therefore compares the design's state with the model's state for the same cycle.

// File: rtl/sdirq_pkg.sv
package sdirq_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned SEL_W    = 3;
    localparam int unsigned ERR_LSB  = 16;
    localparam int unsigned SUM_BIT  = 15;

    // Normal events: 0,1,3,4,5,6,8. Error events: 16..22, 24, 28.
    localparam logic [WORD_W-1:0] IMPL_BITS = 32'h117F_017B;

    typedef enum logic [SEL_W-1:0] {
        SEL_STATUS  = 3'd0,
        SEL_CAPT_EN = 3'd1,
        SEL_LINE_EN = 3'd2,
        SEL_BUSY    = 3'd3
    } word_sel_e;

    typedef struct packed {
        logic dat_active;
        logic dat_busy;
        logic cmd_busy;
    } busy_t;

    typedef struct packed {
        logic clr_status;
        logic wr_capt;
        logic wr_line;
    } wr_strobe_t;

    function automatic wr_strobe_t decode_write(input logic [SEL_W-1:0] sel,
                                                input logic wr);
        wr_strobe_t s;
        s.clr_status = wr && (sel == SEL_STATUS);
        s.wr_capt    = wr && (sel == SEL_CAPT_EN);
        s.wr_line    = wr && (sel == SEL_LINE_EN);
        return s;
    endfunction

endpackage

// File: rtl/sdirq_enable_reg.sv
module sdirq_enable_reg #(
    parameter int unsigned         W    = 32,
    parameter logic [W-1:0]        KEEP = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (we)
            q <= wdata & KEEP;
    end
endmodule

// File: rtl/sdirq_status_bits.sv
module sdirq_status_bits #(
    parameter int unsigned  W    = 32,
    parameter logic [W-1:0] KEEP = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_we,
    input  logic [W-1:0] clr_data,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] capt_en,
    output logic [W-1:0] q
);
    logic [W-1:0] set_v;
    logic [W-1:0] clr_v;
    logic [W-1:0] nxt;

    assign set_v = evt & capt_en & KEEP;
    assign clr_v = clr_we ? clr_data : '0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (KEEP[i]) begin : g_live
            // a new event outranks a clear in the same cycle
            assign nxt[i] = set_v[i] | (q[i] & ~clr_v[i]);
        end else begin : g_tied
            assign nxt[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= nxt;
    end
endmodule

// File: rtl/sdirq_readmux.sv
module sdirq_readmux
    import sdirq_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [W-1:0]     status,
    input  logic             err_sum,
    input  logic [W-1:0]     capt_en,
    input  logic [W-1:0]     line_en,
    input  busy_t            busy,
    output logic [W-1:0]     rdata
);
    localparam int unsigned BUSY_W = $bits(busy_t);

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_STATUS: begin
                rdata          = status;
                rdata[SUM_BIT] = err_sum;
            end
            SEL_CAPT_EN: rdata = capt_en;
            SEL_LINE_EN: rdata = line_en;
            SEL_BUSY:    rdata[BUSY_W-1:0] = busy;
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/sd_irq_unit.sv
module sd_irq_unit
    import sdirq_pkg::*;
#(
    parameter int unsigned           W    = WORD_W,
    parameter logic [WORD_W-1:0]     KEEP = IMPL_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] reg_addr,
    input  logic             reg_wr,
    input  logic [W-1:0]     reg_wdata,
    output logic [W-1:0]     reg_rdata,
    input  logic [W-1:0]     evt_in,
    input  logic             cmd_busy_in,
    input  logic             dat_busy_in,
    input  logic             dat_active_in,
    output logic             irq
);
    localparam logic [W-1:0] ERR_FIELD = ~((W'(1) << ERR_LSB) - W'(1));

    wr_strobe_t   stb;
    logic [W-1:0] status_q;
    logic [W-1:0] capt_en_q;
    logic [W-1:0] line_en_q;
    busy_t        busy;
    logic         err_sum;

    assign stb  = decode_write(reg_addr, reg_wr);
    assign busy = '{dat_active: dat_active_in, dat_busy: dat_busy_in, cmd_busy: cmd_busy_in};

    sdirq_enable_reg #(.W(W), .KEEP(KEEP[W-1:0])) u_capt (
        .clk(clk), .rst(rst), .we(stb.wr_capt), .wdata(reg_wdata), .q(capt_en_q)
    );

    sdirq_enable_reg #(.W(W), .KEEP(KEEP[W-1:0])) u_line (
        .clk(clk), .rst(rst), .we(stb.wr_line), .wdata(reg_wdata), .q(line_en_q)
    );

    sdirq_status_bits #(.W(W), .KEEP(KEEP[W-1:0])) u_stat (
        .clk(clk), .rst(rst), .clr_we(stb.clr_status), .clr_data(reg_wdata),
        .evt(evt_in), .capt_en(capt_en_q), .q(status_q)
    );

    assign err_sum = |(status_q & ERR_FIELD);
    assign irq     = |(status_q & line_en_q);

    sdirq_readmux #(.W(W)) u_rd (
        .sel(reg_addr), .status(status_q), .err_sum(err_sum),
        .capt_en(capt_en_q), .line_en(line_en_q), .busy(busy), .rdata(reg_rdata)
    );
endmodule

// File: rtl/sdirq_checker.sv
module sdirq_checker #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic [2:0]   reg_addr,
    input logic         reg_wr,
    input logic [W-1:0] reg_wdata,
    input logic [W-1:0] evt_in,
    input logic         irq,
    input logic [W-1:0] status_q,
    input logic [W-1:0] capt_en_q
);
    // R2 and R10: without a status clear, no captured bit drops
    p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_addr == 3'd0) |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R3: a newly set bit had its capture enable on
    p_capture_mask_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(capt_en_q)) == '0));

    // R4: a clear with no events removes the written bits
    p_w1c_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 3'd0 && evt_in == '0) |=> ((status_q & $past(reg_wdata)) == '0));

    // R5: enabled events always land, even against a clear
    p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & $past(evt_in & capt_en_q)) == $past(evt_in & capt_en_q)));

    // R6: the line only rises after an event or a line-enable write
    p_irq_cause_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(evt_in != '0 || (reg_wr && reg_addr == 3'd2)));
endmodule

bind sd_irq_unit sdirq_checker #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .evt_in(evt_in), .irq(irq),
    .status_q(status_q), .capt_en_q(capt_en_q)
);

// File: tb/tb_sd_irq_unit.sv
`timescale 1ns/1ps
module tb_sd_irq_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] evt_in = '0;
    logic        cmd_busy_in = 1'b0;
    logic        dat_busy_in = 1'b0;
    logic        dat_active_in = 1'b0;
    logic        irq;

    int compared = 0;
    int mismatched = 0;

    localparam logic [31:0] LIVE = 32'h117F_017B;

    // reference state
    logic [31:0] m_st = '0, m_cap = '0, m_line = '0;

    always #2.5 clk = ~clk;

    sd_irq_unit dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in),
        .cmd_busy_in(cmd_busy_in), .dat_busy_in(dat_busy_in),
        .dat_active_in(dat_active_in), .irq(irq)
    );

    function automatic logic [31:0] model_read(input logic [2:0] a);
        logic [31:0] v;
        case (a)
            3'd0: begin
                v = m_st;
                v[15] = (m_st[31:16] != 16'h0);
            end
            3'd1: v = m_cap;
            3'd2: v = m_line;
            3'd3: v = {29'h0, dat_active_in, dat_busy_in, cmd_busy_in};
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic step(input logic [2:0] a, input logic w, input logic [31:0] d,
                        input logic [31:0] e, input string req);
        logic [31:0] exp_rd;
        logic        exp_irq;
        reg_addr = a; reg_wr = w; reg_wdata = d; evt_in = e;
        #1;
        exp_rd  = model_read(a);
        exp_irq = ((m_st & m_line) != '0);
        compared++;
        if (reg_rdata !== exp_rd || irq !== exp_irq) begin
            mismatched++;
            $display("FAIL %s: sel=%0d rdata=%h irq=%b expected rdata=%h irq=%b",
                     req, a, reg_rdata, irq, exp_rd, exp_irq);
        end
        @(posedge clk);
        if (rst) begin
            m_st = '0; m_cap = '0; m_line = '0;
        end else begin
            logic [31:0] newset;
            newset = e & m_cap & LIVE;
            if (w && a == 3'd0) m_st = m_st & ~d;
            m_st = m_st | newset;
            if (w && a == 3'd1) m_cap = d & LIVE;
            if (w && a == 3'd2) m_line = d & LIVE;
        end
        @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, input string req);
        step(a, 1'b0, '0, '0, req);
    endtask

    initial begin
        #1_000_000;
        mismatched++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 4; i++) step(3'(i), 1'b1, '1, '1, "R1");
        rst = 1'b0;
        for (int i = 0; i < 8; i++) rd(3'(i), "R1");

        // R8: enables keep only live bits
        step(3'd1, 1'b1, '1, '0, "R8");
        rd(3'd1, "R8");
        step(3'd2, 1'b1, '1, '0, "R8");
        rd(3'd2, "R8");
        step(3'd2, 1'b1, '0, '0, "R6");

        // R2: capture and stickiness
        step(3'd0, 1'b0, '0, 32'h0000_0001, "R2");
        rd(3'd0, "R2");
        rd(3'd0, "R2");

        // R7: error summary
        step(3'd0, 1'b0, '0, 32'h0002_0000, "R7");
        rd(3'd0, "R7");

        // R4: partial clear keeps other bits
        step(3'd0, 1'b1, 32'h0000_0001, '0, "R4");
        rd(3'd0, "R4");
        rd(3'd0, "R7");

        // R6: line enable drives irq
        step(3'd2, 1'b1, 32'h0002_0000, '0, "R6");
        rd(3'd0, "R6");
        step(3'd0, 1'b1, 32'h0002_0000, '0, "R6");
        rd(3'd0, "R6");
        step(3'd2, 1'b1, 32'h0000_0012, '0, "R6");
        step(3'd0, 1'b0, '0, 32'h0000_0010, "R6");
        rd(3'd0, "R6");
        step(3'd0, 1'b1, 32'h0000_0010, '0, "R6");
        rd(3'd0, "R6");

        // R3: capture masking
        step(3'd1, 1'b1, ~32'h0000_0020, '0, "R3");
        step(3'd0, 1'b0, '0, 32'h0000_0020, "R3");
        rd(3'd0, "R3");

        // R5: set wins over clear
        step(3'd0, 1'b0, '0, 32'h0000_0002, "R5");
        step(3'd0, 1'b1, 32'h0000_0002, 32'h0000_0002, "R5");
        rd(3'd0, "R5");

        // R8: events on dead bits ignored
        step(3'd0, 1'b0, '0, 32'hEE80_8084, "R8");
        rd(3'd0, "R8");

        // R10: dropping capture enable keeps captured bit
        step(3'd0, 1'b0, '0, 32'h1000_0008, "R10");
        step(3'd1, 1'b1, 32'h0000_0000, '0, "R10");
        rd(3'd0, "R10");
        rd(3'd1, "R10");

        // R9: busy mirror, write ignored
        cmd_busy_in = 1'b1;
        rd(3'd3, "R9");
        dat_busy_in = 1'b1; cmd_busy_in = 1'b0;
        rd(3'd3, "R9");
        dat_active_in = 1'b1;
        step(3'd3, 1'b1, 32'h0000_0000, '0, "R9");
        rd(3'd3, "R9");
        rd(3'd0, "R9");
        rd(3'd1, "R9");
        rd(3'd2, "R9");
        rd(3'd5, "R9");

        // R4: write all ones clears everything
        step(3'd0, 1'b1, '1, '0, "R4");
        rd(3'd0, "R4");
        rd(3'd0, "R4");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule